// File: doc/BRIEF.md
# Pipelined Radix-4 Booth Multiplier

This block multiplies two signed two's-complement operands of N bits each (N even, default 8) and returns the full 2N-bit signed product. One operand pair can be accepted on every clock. The result appears a fixed number of cycles later, marked by a valid strobe. There is no backpressure: the consumer must take each result in the cycle it is presented.

The multiplier operand `op_y` is scanned in overlapping three-bit windows. Each window is turned into a signed digit that picks zero, plus or minus the multiplicand, or plus or minus twice the multiplicand. This produces N/2 partial products. Each partial product is sign-extended to the full product width and weighted by four to the power of its digit index. A negative digit is formed by bitwise inversion plus a one injected at the digit's weight. Those injected ones are collected in a separate correction word. The partial products and the correction word are summed by a registered pairwise tree until two words remain. A generate/propagate lookahead adder then combines those two words into the registered product.

With LVL = ceil(log2(N/2+1)), the pipeline has LAT = LVL + 1 register stages. For N = 8, LAT is 4. An operand pair presented with `in_valid` high in cycle c yields `out_valid` high with its product in cycle c+LAT. The design has no control states: a shift register of valid bits travels alongside the data registers. Reset is synchronous and active high. It clears only the valid bits.

Top module: `booth_mul`

## Requirements
- R1: For every pair of signed operands, `out_prod` equals the two's-complement product op_x × op_y taken to 2N bits; zero in either operand gives zero.
- R2: Digit i is taken from op_y bits {2i+1, 2i, 2i−1}, with a 0 standing below bit 0. Windows 000 and 111 give 0, 001 and 010 give +1, 011 gives +2, 100 gives −2, and 101 and 110 give −1. Every one of the 2^N multiplier values must give the right product.
- R3: Exactly N/2 partial products are formed. Partial product i carries weight 4^i, so a multiplier of 4^i gives op_x shifted left by 2i with sign extension.
- R4: Negative digits and the ×2 selection stay correct at the extremes. For N = 8, (−128)×(−128) = +16384 and (−128)×(−1) = +128.
- R5: `out_valid` in cycle c+LAT equals `in_valid` in cycle c, where LAT = ceil(log2(N/2+1)) + 1. Cycles without `in_valid` produce cycles without `out_valid`.
- R6: Back-to-back operand pairs, one per cycle, each emerge in order with their own product.
- R7: Reset clears every pipeline valid bit. `out_valid` is low in the cycle after reset is applied, and no pair that was in flight when reset was applied appears afterwards.
- R8: The final adder is a generate/propagate carry-lookahead adder whose carries reach across the whole 2N-bit width. For example, (−1)×(+1) gives an all-ones product.
- R9: For N = 8, (−118)×(−99) yields +11682 (0x2DA2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Operand pair on `op_x`/`op_y` is to be multiplied |
| op_x | input | N | Signed multiplicand |
| op_y | input | N | Signed multiplier (the recoded operand) |
| out_valid | output | 1 | `out_prod` holds the product of the pair accepted LAT cycles earlier |
| out_prod | output | 2N | Signed product |

## Verification
A corrupted digit or a wrong partial-product weight shows as a wrong `out_prod` exactly LAT cycles after the affected pair enters. Sweeping every multiplier value against a fixed multiplicand makes each recoding window and sign path visible. A broken carry chain in the final adder shows up in products whose carries must travel the full width, such as −1 and the most negative value. A stuck or misplaced valid bit shows as `out_valid` disagreeing with the delayed `in_valid` on the very cycle it reaches the output. A reference model in the bench compares these on every clock, including the cycles around a reset applied mid-stream.

// File: rtl/booth_pkg.sv
package booth_pkg;

    // One recoded multiplier digit: value = (neg ? -1 : +1) * (two ? 2 : one ? 1 : 0)
    typedef struct packed {
        logic neg;
        logic two;
        logic one;
    } booth_digit_t;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
    import booth_pkg::*;
(
    input  logic [2:0]   trip,
    output booth_digit_t dig
);

    always_comb begin
        dig = '0;
        unique case (trip)
            3'b000, 3'b111: dig = '{neg: 1'b0, two: 1'b0, one: 1'b0};
            3'b001, 3'b010: dig = '{neg: 1'b0, two: 1'b0, one: 1'b1};
            3'b011:         dig = '{neg: 1'b0, two: 1'b1, one: 1'b0};
            3'b100:         dig = '{neg: 1'b1, two: 1'b1, one: 1'b0};
            3'b101, 3'b110: dig = '{neg: 1'b1, two: 1'b0, one: 1'b1};
            default:        dig = '0;
        endcase
    end

endmodule

// File: rtl/booth_ppsel.sv
module booth_ppsel
    import booth_pkg::*;
#(
    parameter int N   = 8,
    parameter int IDX = 0
) (
    input  logic [N-1:0]   mcand,
    input  booth_digit_t   dig,
    output logic [2*N-1:0] pp
);

    localparam int W = 2 * N;

    logic [W-1:0] ext;
    logic [W-1:0] mag;
    logic [W-1:0] inv;

    // sign-extend first so the doubled value keeps its sign
    assign ext = {{N{mcand[N-1]}}, mcand};

    always_comb begin
        if (dig.two)
            mag = ext << 1;
        else if (dig.one)
            mag = ext;
        else
            mag = '0;
        // the +1 of the negation is carried in the correction word
        inv = dig.neg ? ~mag : mag;
        pp  = inv << (2 * IDX);
    end

endmodule

// File: rtl/booth_cla.sv
module booth_cla #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s
);

    logic [W-1:0] gen;
    logic [W-1:0] prop;
    logic [W-1:0] cin;

    assign gen  = a & b;
    assign prop = a | b;

    always_comb begin
        cin[0] = 1'b0;
        for (int k = 0; k < W - 1; k++) begin
            cin[k+1] = gen[k] | (prop[k] & cin[k]);
        end
        s = a ^ b ^ cin;
    end

endmodule

// File: rtl/booth_mul.sv
module booth_mul
    import booth_pkg::*;
#(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [N-1:0]   op_x,
    input  logic [N-1:0]   op_y,
    output logic           out_valid,
    output logic [2*N-1:0] out_prod
);

    localparam int W     = 2 * N;
    localparam int NPP   = N / 2;
    localparam int NTERM = NPP + 1;
    localparam int LVL   = $clog2(NTERM);
    localparam int P2    = 1 << LVL;
    localparam int LAT   = LVL + 1;
    localparam int WW    = $clog2(LAT + 1);

    // ---------------- recoding and partial products ----------------
    logic [N:0]   y_ext;
    booth_digit_t dig [NPP];
    logic [W-1:0] pp  [NPP];
    logic [W-1:0] cor;
    logic [W-1:0] term [P2];

    assign y_ext = {op_y, 1'b0};

    for (genvar i = 0; i < NPP; i++) begin : g_digit
        booth_recode u_rec (
            .trip (y_ext[2*i+2 -: 3]),
            .dig  (dig[i])
        );
        booth_ppsel #(.N(N), .IDX(i)) u_sel (
            .mcand (op_x),
            .dig   (dig[i]),
            .pp    (pp[i])
        );
    end

    always_comb begin
        cor = '0;
        for (int i = 0; i < NPP; i++) begin
            cor[2*i] = dig[i].neg;
        end
        for (int k = 0; k < P2; k++) begin
            term[k] = '0;
        end
        for (int i = 0; i < NPP; i++) begin
            term[i] = pp[i];
        end
        term[NPP] = cor;
    end

    // ---------------- registered reduction tree ----------------
    for (genvar l = 0; l < LVL; l++) begin : g_lvl
        localparam int CNT = P2 >> l;
        logic [W-1:0] node [CNT];
        if (l == 0) begin : g_leaf
            always_ff @(posedge clk) begin
                for (int j = 0; j < CNT; j++) begin
                    node[j] <= term[j];
                end
            end
        end else begin : g_sum
            always_ff @(posedge clk) begin
                for (int j = 0; j < CNT; j++) begin
                    node[j] <= g_lvl[l-1].node[2*j] + g_lvl[l-1].node[2*j+1];
                end
            end
        end
    end

    // ---------------- lookahead final adder ----------------
    logic [W-1:0] fin_a;
    logic [W-1:0] fin_b;
    logic [W-1:0] fin_sum;

    assign fin_a = g_lvl[LVL-1].node[0];
    assign fin_b = g_lvl[LVL-1].node[1];

    booth_cla #(.W(W)) u_cla (
        .a (fin_a),
        .b (fin_b),
        .s (fin_sum)
    );

    always_ff @(posedge clk) begin
        out_prod <= fin_sum;
    end

    // ---------------- valid pipeline ----------------
    logic [LAT-1:0] vld;

    always_ff @(posedge clk) begin
        if (rst)
            vld <= '0;
        else
            vld <= {vld[LAT-2:0], in_valid};
    end

    assign out_valid = vld[LAT-1];

    // ---------------- assertions ----------------
    logic [WW-1:0]         warm;
    logic signed [W-1:0]   chk_x;
    logic signed [W-1:0]   chk_y;

    assign chk_x = {{N{op_x[N-1]}}, op_x};
    assign chk_y = {{N{op_y[N-1]}}, op_y};

    always_ff @(posedge clk) begin
        if (rst)
            warm <= '0;
        else if (warm != WW'(LAT))
            warm <= warm + 1'b1;
    end

    AST_PRODUCT_MATCH: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_prod == W'($past(chk_x, LAT) * $past(chk_y, LAT))))
        else $error("product mismatch");                                   // R1

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
        (warm == WW'(LAT)) |-> (out_valid == $past(in_valid, LAT)))
        else $error("valid delay mismatch");                               // R5

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !out_valid)
        else $error("valid survived reset");                               // R7

    AST_CLA_SUM: assert property (@(posedge clk) disable iff (rst)
        vld[LAT-2] |-> (fin_sum == W'(fin_a + fin_b)))
        else $error("final adder sum wrong");                              // R8

endmodule

// File: tb/sim_booth_mul.sv
module sim_booth_mul;

    localparam int N    = 8;
    localparam int W    = 2 * N;
    localparam int LAT  = $clog2(N / 2 + 1) + 1;
    localparam int MAXC = 8192;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [N-1:0] op_x;
    logic [N-1:0] op_y;
    logic         out_valid;
    logic [W-1:0] out_prod;

    always #5 clk = ~clk;

    booth_mul #(.N(N)) u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op_x      (op_x),
        .op_y      (op_y),
        .out_valid (out_valid),
        .out_prod  (out_prod)
    );

    int           checks = 0;
    int           fails  = 0;
    int           cyc    = 0;
    bit           done   = 0;
    bit           hv [MAXC];
    logic [W-1:0] hp [MAXC];
    string        ht [MAXC];

    function automatic logic [W-1:0] ref_mul(input logic [N-1:0] x, input logic [N-1:0] y);
        logic signed [W-1:0] sx;
        logic signed [W-1:0] sy;
        sx = {{N{x[N-1]}}, x};
        sy = {{N{y[N-1]}}, y};
        return sx * sy;
    endfunction

    // check the outputs of this cycle, then drive the inputs of this cycle
    task automatic step(input bit r, input bit v, input logic [N-1:0] x,
                        input logic [N-1:0] y, input string tag);
        bit           ev;
        logic [W-1:0] ep;
        string        et;
        @(negedge clk);
        if (cyc > 0) begin
            ev = 1'b0;
            ep = '0;
            et = "R7";
            if (cyc >= LAT) begin
                ev = hv[cyc-LAT];
                ep = hp[cyc-LAT];
                et = ht[cyc-LAT];
            end
            checks++;
            if (out_valid !== ev) begin
                fails++;
                $display("FAIL %s valid cyc=%0d actual=%b expected=%b", et, cyc, out_valid, ev);
            end
            if (ev) begin
                checks++;
                if (out_prod !== ep) begin
                    fails++;
                    $display("FAIL %s product cyc=%0d actual=%h expected=%h", et, cyc, out_prod, ep);
                end
            end
        end
        rst      = r;
        in_valid = v;
        op_x     = x;
        op_y     = y;
        hv[cyc]  = v && !r;
        hp[cyc]  = ref_mul(x, y);
        ht[cyc]  = tag;
        if (r) begin
            // pairs still in flight are flushed by reset (R7)
            for (int k = cyc - LAT + 1; k < cyc; k++) begin
                if (k >= 0) begin
                    hv[k] = 1'b0;
                end
            end
        end
        cyc++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; op_x = '0; op_y = '0;
        // R7: reset state, out_valid must stay low
        repeat (4) step(1'b1, 1'b0, '0, '0, "R7");
        // R9: worked example
        step(1'b0, 1'b1, N'(-118), N'(-99), "R9");
        // R4: extremes
        step(1'b0, 1'b1, 8'h80, 8'h80, "R4");
        step(1'b0, 1'b1, 8'h80, 8'hFF, "R4");
        step(1'b0, 1'b1, 8'hFF, 8'h80, "R4");
        step(1'b0, 1'b1, 8'h7F, 8'h80, "R4");
        step(1'b0, 1'b1, 8'h7F, 8'h7F, "R4");
        // R8: carries across the full width
        step(1'b0, 1'b1, 8'hFF, 8'h01, "R8");
        step(1'b0, 1'b1, 8'h01, 8'hFF, "R8");
        step(1'b0, 1'b1, 8'hFF, 8'hFF, "R8");
        // R1: zero operands
        step(1'b0, 1'b1, 8'h00, 8'h9D, "R1");
        step(1'b0, 1'b1, 8'hA5, 8'h00, "R1");
        step(1'b0, 1'b1, 8'h00, 8'h00, "R1");
        // R3: partial-product weights
        step(1'b0, 1'b1, 8'hB7, 8'h01, "R3");
        step(1'b0, 1'b1, 8'hB7, 8'h04, "R3");
        step(1'b0, 1'b1, 8'hB7, 8'h10, "R3");
        step(1'b0, 1'b1, 8'hB7, 8'h40, "R3");
        step(1'b0, 1'b1, 8'h5B, 8'h02, "R3");
        step(1'b0, 1'b1, 8'h5B, 8'h20, "R3");
        // R2: every multiplier value, two multiplicands
        for (int y = 0; y < (1 << N); y++) step(1'b0, 1'b1, 8'd77, N'(y), "R2");
        for (int y = 0; y < (1 << N); y++) step(1'b0, 1'b1, 8'h83, N'(y), "R2");
        // R6: back-to-back random pairs
        for (int k = 0; k < 600; k++) step(1'b0, 1'b1, N'($urandom), N'($urandom), "R6");
        // R5: random pairs with bubbles
        for (int k = 0; k < 600; k++) step(1'b0, 1'($urandom % 2), N'($urandom), N'($urandom), "R5");
        // R7: reset applied while the pipeline is full
        for (int k = 0; k < LAT; k++) step(1'b0, 1'b1, N'($urandom), N'($urandom), "R7");
        step(1'b1, 1'b1, 8'h12, 8'h34, "R7");
        step(1'b1, 1'b0, '0, '0, "R7");
        for (int k = 0; k < 2 * LAT; k++) step(1'b0, 1'($urandom % 2), N'($urandom), N'($urandom), "R5");
        // drain
        repeat (LAT + 2) step(1'b0, 1'b0, '0, '0, "R5");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule